// File: doc/BRIEF.md
# Assembly Site Acceptance Controller

This controller sits on an active assembly substrate made of a rectangular grid of binding sites. A presence sensor at each site reports whether a part is sitting in it. When a part lands in an empty site, the controller asks for the part's type through a tag query port. It then decides whether to keep the part or push it off. The grid is split into square regions of `SLACK` x `SLACK` sites. Each region holds one outstanding-part counter per type. A part is kept when its region still needs a part of that type, so it may sit on any site of the region. A part that is not needed is rejected by raising that site's repel output for a programmable number of cycles.

Sites are visited by a pointer that steps once per cycle in a circle, so only one tag query is ever in flight. A query that gets no reply within `TIMEOUT` cycles ends in a reject. A kept part that later falls out of its site frees the site again and gives its region the requirement back. Counters are loaded through a configuration write port before assembly starts. `allDone` is high whenever every counter of every region is zero.

Top module: `siteAcceptCtrl`

## Requirements
- R1: After reset, `siteKept`, `siteReject` and `qryReq` are all zero. Every counter is zero, so `allDone` is 1.
- R2: When `cfgWrEn` is high, the counter selected by `cfgRegion` and `cfgType` is loaded with `cfgCount` on that edge. The load overrides any change to that counter in the same cycle.
- R3: An occupied site in the empty state is queried when the scan pointer reaches it. During a query, `qryReq` stays high and `qrySite` holds the site index, which is y*GRID_W+x in row-major order. At most one query is in flight, and every waiting site is served.
- R4: On a reply (`qryAck` high), the part is kept when the counter for its region and tag `qryType` is non-zero. A kept part sets the site's `siteKept` and decrements that counter. The region of site (x,y) is (y/SLACK)*ceil(GRID_W/SLACK)+x/SLACK, so any site of the region serves its requirement. With SLACK=1 every site is its own region.
- R5: On a reply whose counter is zero, or whose tag is NUM_TYPES or higher, the site is rejected and no counter changes.
- R6: A rejected site keeps `siteReject` high for exactly `rejHold` cycles, or for 1 cycle when `rejHold` is 0, and then becomes empty. Its presence input is ignored while the reject lasts.
- R7: When `qryAck` does not arrive within `TIMEOUT` cycles of `qryReq`, the query ends after exactly `TIMEOUT` cycles with a reject.
- R8: When a kept part leaves (its `siteOcc` goes low), `siteKept` falls on the next edge and the counter for its region and type goes up by one.
- R9: When a part leaves its site during its query, the query is dropped. No reject is raised and no counter changes.
- R10: `allDone` is 1 exactly when every counter in every region is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Counter load strobe |
| cfgRegion | input | REG_W | Region of the counter to load |
| cfgType | input | TAG_W (3) | Type of the counter to load |
| cfgCount | input | CNT_W | Value to load |
| rejHold | input | HOLD_W | Reject hold length in cycles |
| siteOcc | input | NSITES | Presence sensor, one bit per site |
| qryReq | output | 1 | Tag query in flight |
| qrySite | output | SITE_W | Site being queried |
| qryAck | input | 1 | Tag reply valid |
| qryType | input | TAG_W (3) | Type tag of the queried part |
| siteKept | output | NSITES | Site holds an accepted part |
| siteReject | output | NSITES | Site surface set to repel |
| allDone | output | 1 | All requirements met |

## Verification
A counter that is off by one, or that belongs to the wrong region, shows up at the next arrival of that type anywhere in the region. It appears as a keep where a reject is due, or the reverse, within one scan plus one reply. It also shows at once as a wrong `allDone` level. A site state that sticks shows as a missing `qryReq` for an occupied site, a wrong reject length, or a `siteKept` that stays high after the part has left. The bench sweeps every tag value against one region's counters, and also covers the slack regions, timeouts, aborted queries and departures.

// File: rtl/siteAcceptPkg.sv
package siteAcceptPkg;
  localparam int TAG_W = 3;

  typedef enum logic [1:0] {ST_EMPTY, ST_QUERY, ST_KEPT, ST_REJECT} siteStateE;

  typedef struct packed {
    logic             start;
    logic             accept;
    logic             reject;
    logic             abort;
    logic [TAG_W-1:0] tag;
  } ctlStrbT;
endpackage

// File: rtl/siteAcceptCtl.sv
module siteAcceptCtl
  import siteAcceptPkg::*;
#(
  parameter int NSITES    = 16,
  parameter int SITE_W    = 4,
  parameter int NUM_TYPES = 5,
  parameter int TIMEOUT   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NSITES-1:0]    siteOcc,
  input  logic [NSITES-1:0]    siteIdle,
  input  logic [NUM_TYPES-1:0] needVec,
  input  logic                 qryAck,
  input  logic [TAG_W-1:0]     qryType,
  output logic                 qryReq,
  output logic [SITE_W-1:0]    curSite,
  output ctlStrbT              strb
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  typedef enum logic {C_SCAN, C_QUERY} ctlStateE;

  ctlStateE                stQ;
  logic [SITE_W-1:0]       ptrQ;
  logic [TO_W-1:0]         waitQ;
  logic [(1<<TAG_W)-1:0]   needPad;
  logic                    tagHit;
  logic [SITE_W-1:0]       ptrNext;

  // tags at or above NUM_TYPES read a zero and therefore mismatch
  always_comb begin
    needPad = '0;
    needPad[NUM_TYPES-1:0] = needVec;
  end
  assign tagHit  = needPad[qryType];
  assign ptrNext = (ptrQ == SITE_W'(NSITES - 1)) ? '0 : ptrQ + SITE_W'(1);

  always_comb begin
    strb     = '0;
    strb.tag = qryType;
    if (stQ == C_SCAN) begin
      strb.start = siteOcc[ptrQ] && siteIdle[ptrQ];
    end else if (!siteOcc[ptrQ]) begin
      strb.abort = 1'b1;
    end else if (qryAck) begin
      strb.accept = tagHit;
      strb.reject = !tagHit;
    end else if (waitQ == TO_W'(TIMEOUT - 1)) begin
      strb.reject = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= C_SCAN;
      ptrQ  <= '0;
      waitQ <= '0;
    end else if (stQ == C_SCAN) begin
      if (strb.start) begin
        stQ   <= C_QUERY;
        waitQ <= '0;
      end else begin
        ptrQ <= ptrNext;
      end
    end else begin
      if (strb.abort || strb.accept || strb.reject) begin
        stQ  <= C_SCAN;
        ptrQ <= ptrNext;
      end else begin
        waitQ <= waitQ + TO_W'(1);
      end
    end
  end

  assign qryReq  = (stQ == C_QUERY);
  assign curSite = ptrQ;
endmodule

// File: rtl/siteAcceptDp.sv
module siteAcceptDp
  import siteAcceptPkg::*;
#(
  parameter int GRID_W    = 4,
  parameter int GRID_H    = 4,
  parameter int SLACK     = 2,
  parameter int NUM_TYPES = 5,
  parameter int CNT_W     = 4,
  parameter int HOLD_W    = 4,
  parameter int NSITES    = 16,
  parameter int SITE_W    = 4,
  parameter int REG_COLS  = 2,
  parameter int NREG      = 4,
  parameter int REG_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [REG_W-1:0]     cfgRegion,
  input  logic [TAG_W-1:0]     cfgType,
  input  logic [CNT_W-1:0]     cfgCount,
  input  logic [HOLD_W-1:0]    rejHold,
  input  logic [NSITES-1:0]    siteOcc,
  input  logic [SITE_W-1:0]    curSite,
  input  ctlStrbT              strb,
  output logic [NUM_TYPES-1:0] needVec,
  output logic [NSITES-1:0]    siteIdle,
  output logic [NSITES-1:0]    siteKept,
  output logic [NSITES-1:0]    siteReject,
  output logic                 allDone
);
  localparam int CNT_TOTAL = NREG * NUM_TYPES;

  logic [REG_W-1:0]            siteReg [NSITES];
  logic [NSITES-1:0]           leaving;
  logic [NSITES*TAG_W-1:0]     tagFlat;
  logic [CNT_TOTAL*CNT_W-1:0]  cntFlat;
  logic [REG_W-1:0]            curReg;

  assign curReg = siteReg[curSite];

  for (genvar s = 0; s < NSITES; s++) begin : g_site
    localparam int SX = s % GRID_W;
    localparam int SY = s / GRID_W;

    siteStateE         stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [HOLD_W-1:0] holdQ;
    logic              sel;

    assign siteReg[s] = REG_W'((SY / SLACK) * REG_COLS + SX / SLACK);
    assign sel        = (curSite == SITE_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ   <= ST_EMPTY;
        tagQ  <= '0;
        holdQ <= '0;
      end else begin
        case (stQ)
          ST_EMPTY: if (sel && strb.start) stQ <= ST_QUERY;
          ST_QUERY: if (sel) begin
            if (strb.abort) begin
              stQ <= ST_EMPTY;
            end else if (strb.accept) begin
              stQ  <= ST_KEPT;
              tagQ <= strb.tag;
            end else if (strb.reject) begin
              stQ   <= ST_REJECT;
              holdQ <= (rejHold == '0) ? HOLD_W'(1) : rejHold;
            end
          end
          ST_KEPT: if (!siteOcc[s]) stQ <= ST_EMPTY;
          default: begin
            if (holdQ <= HOLD_W'(1)) stQ <= ST_EMPTY;
            else holdQ <= holdQ - HOLD_W'(1);
          end
        endcase
      end
    end

    assign siteIdle[s]                 = (stQ == ST_EMPTY);
    assign siteKept[s]                 = (stQ == ST_KEPT);
    assign siteReject[s]               = (stQ == ST_REJECT);
    assign leaving[s]                  = (stQ == ST_KEPT) && !siteOcc[s];
    assign tagFlat[s*TAG_W +: TAG_W]   = tagQ;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
      logic [CNT_W-1:0] cntQ;
      logic [CNT_W-1:0] incN;
      logic             decHit;
      logic             cfgHit;

      // several parts of one region may leave in the same cycle
      always_comb begin
        incN = '0;
        for (int s = 0; s < NSITES; s++) begin
          if (leaving[s] && siteReg[s] == REG_W'(r) &&
              tagFlat[s*TAG_W +: TAG_W] == TAG_W'(t))
            incN = incN + CNT_W'(1);
        end
      end

      assign decHit = strb.accept && curReg == REG_W'(r) && strb.tag == TAG_W'(t);
      assign cfgHit = cfgWrEn && cfgRegion == REG_W'(r) && cfgType == TAG_W'(t);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       cntQ <= '0;
        else if (cfgHit) cntQ <= cfgCount;
        else             cntQ <= cntQ + incN - CNT_W'(decHit);
      end

      assign cntFlat[(r*NUM_TYPES + t)*CNT_W +: CNT_W] = cntQ;
    end
  end

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_need
    assign needVec[t] = cntFlat[(int'(curReg)*NUM_TYPES + t)*CNT_W +: CNT_W] != '0;
  end

  assign allDone = (cntFlat == '0);
endmodule

// File: rtl/siteAcceptCtrl.sv
module siteAcceptCtrl
  import siteAcceptPkg::*;
#(
  parameter int GRID_W    = 4,
  parameter int GRID_H    = 4,
  parameter int SLACK     = 2,
  parameter int NUM_TYPES = 5,
  parameter int CNT_W     = 4,
  parameter int HOLD_W    = 4,
  parameter int TIMEOUT   = 8,
  localparam int NSITES   = GRID_W * GRID_H,
  localparam int SITE_W   = (NSITES > 1) ? $clog2(NSITES) : 1,
  localparam int REG_COLS = (GRID_W + SLACK - 1) / SLACK,
  localparam int REG_ROWS = (GRID_H + SLACK - 1) / SLACK,
  localparam int NREG     = REG_COLS * REG_ROWS,
  localparam int REG_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [REG_W-1:0]  cfgRegion,
  input  logic [TAG_W-1:0]  cfgType,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [HOLD_W-1:0] rejHold,
  input  logic [NSITES-1:0] siteOcc,
  output logic              qryReq,
  output logic [SITE_W-1:0] qrySite,
  input  logic              qryAck,
  input  logic [TAG_W-1:0]  qryType,
  output logic [NSITES-1:0] siteKept,
  output logic [NSITES-1:0] siteReject,
  output logic              allDone
);
  ctlStrbT                strb;
  logic [SITE_W-1:0]      curSite;
  logic [NUM_TYPES-1:0]   needVec;
  logic [NSITES-1:0]      siteIdle;

  siteAcceptCtl #(
    .NSITES(NSITES), .SITE_W(SITE_W), .NUM_TYPES(NUM_TYPES), .TIMEOUT(TIMEOUT)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .siteOcc(siteOcc), .siteIdle(siteIdle),
    .needVec(needVec), .qryAck(qryAck), .qryType(qryType),
    .qryReq(qryReq), .curSite(curSite), .strb(strb)
  );

  siteAcceptDp #(
    .GRID_W(GRID_W), .GRID_H(GRID_H), .SLACK(SLACK), .NUM_TYPES(NUM_TYPES),
    .CNT_W(CNT_W), .HOLD_W(HOLD_W), .NSITES(NSITES), .SITE_W(SITE_W),
    .REG_COLS(REG_COLS), .NREG(NREG), .REG_W(REG_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRegion(cfgRegion),
    .cfgType(cfgType), .cfgCount(cfgCount), .rejHold(rejHold),
    .siteOcc(siteOcc), .curSite(curSite), .strb(strb), .needVec(needVec),
    .siteIdle(siteIdle), .siteKept(siteKept), .siteReject(siteReject),
    .allDone(allDone)
  );

  assign qrySite = curSite;
endmodule

// File: rtl/siteAcceptChk.sv
module siteAcceptChk #(
  parameter int NSITES  = 16,
  parameter int SITE_W  = 4,
  parameter int TIMEOUT = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              qryReq,
  input logic [SITE_W-1:0] qrySite,
  input logic              qryAck,
  input logic [NSITES-1:0] siteKept,
  input logic [NSITES-1:0] siteReject
);
  int qCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       qCnt <= 0;
    else if (qryReq) qCnt <= qCnt + 1;
    else             qCnt <= 0;
  end

  // R3
  query_site_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryReq && $past(qryReq) |-> qrySite == $past(qrySite));

  // R3
  single_reject_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(siteReject & ~$past(siteReject)));

  // R4
  keep_after_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (siteKept & ~$past(siteKept)) != '0 |-> $past(qryReq) && $past(qryAck));

  // R5
  reject_after_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    (siteReject & ~$past(siteReject)) != '0 |-> $past(qryReq));

  // R6
  keep_reject_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (siteKept & siteReject) == '0);

  // R7
  query_timeout_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCnt <= TIMEOUT);
endmodule

bind siteAcceptCtrl siteAcceptChk #(
  .NSITES(NSITES), .SITE_W(SITE_W), .TIMEOUT(TIMEOUT)
) i_siteAcceptChk (
  .clk(clk), .rstN(rstN), .qryReq(qryReq), .qrySite(qrySite), .qryAck(qryAck),
  .siteKept(siteKept), .siteReject(siteReject)
);

// File: tb/test_siteAcceptCtrl.sv
module test_siteAcceptCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgRegion;
  logic [2:0]  cfgType;
  logic [3:0]  cfgCount;
  logic [3:0]  rejHold;
  logic [15:0] occ;
  logic        qryReq;
  logic [3:0]  qrySite;
  logic        qryAck;
  logic [2:0]  qryType;
  logic [15:0] siteKept;
  logic [15:0] siteReject;
  logic        allDone;

  logic [2:0]  tagOf [16];
  bit          silent [16];
  int          checks = 0;
  int          fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  siteAcceptCtrl #(.TIMEOUT(TIMEOUT)) i_siteAcceptCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRegion(cfgRegion),
    .cfgType(cfgType), .cfgCount(cfgCount), .rejHold(rejHold), .siteOcc(occ),
    .qryReq(qryReq), .qrySite(qrySite), .qryAck(qryAck), .qryType(qryType),
    .siteKept(siteKept), .siteReject(siteReject), .allDone(allDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // tag responder: answers one cycle after a query is seen unless muted
  initial begin
    qryAck  = 1'b0;
    qryType = '0;
    forever begin
      @(negedge clk);
      if (qryReq && !qryAck && !silent[qrySite]) begin
        qryAck  = 1'b1;
        qryType = tagOf[qrySite];
      end else begin
        qryAck = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic cfgWrite(input int r, input int t, input int c);
    cfgWrEn   = 1'b1;
    cfgRegion = 2'(r);
    cfgType   = 3'(t);
    cfgCount  = 4'(c);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic place(input int s, input int tag, input bit mute);
    tagOf[s]  = 3'(tag);
    silent[s] = mute;
    occ[s]    = 1'b1;
  endtask

  // waits for keep or reject; on reject, removes the part and measures hold
  task automatic outcome(input int s, output int kept, output int rejLen,
                         output int qCycles);
    kept = -1; rejLen = 0; qCycles = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (qryReq && qrySite == 4'(s)) qCycles++;
      if (siteKept[s]) begin
        kept = 1;
        return;
      end
      if (siteReject[s]) begin
        kept = 0;
        while (siteReject[s]) begin
          rejLen++;
          occ[s] = 1'b0;
          @(negedge clk);
        end
        return;
      end
    end
  endtask

  int kept, rejLen, qCycles;

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgRegion = '0; cfgType = '0; cfgCount = '0;
    rejHold = 4'd3; occ = '0;
    for (int i = 0; i < 16; i++) begin tagOf[i] = '0; silent[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(siteKept == '0, "R1", "siteKept", int'(siteKept), 0);
    check(siteReject == '0, "R1", "siteReject", int'(siteReject), 0);
    check(qryReq == 1'b0, "R1", "qryReq", int'(qryReq), 0);
    check(allDone == 1'b1, "R1", "allDone", int'(allDone), 1);

    // R2 R10 load counters
    cfgWrite(0, 2, 2);
    cfgWrite(1, 0, 1);
    cfgWrite(3, 4, 1);
    check(allDone == 1'b0, "R10", "allDone after load", int'(allDone), 0);

    // R4 two type-2 parts land on different sites of region 0
    place(0, 2, 0); outcome(0, kept, rejLen, qCycles);
    check(kept == 1, "R4", "site0 kept", kept, 1);
    place(5, 2, 0); outcome(5, kept, rejLen, qCycles);
    check(kept == 1, "R4", "site5 kept via slack", kept, 1);
    // R5 R6 region 0 no longer needs type 2
    place(4, 2, 0); outcome(4, kept, rejLen, qCycles);
    check(kept == 0, "R5", "site4 rejected", kept, 0);
    check(rejLen == 3, "R6", "reject hold 3", rejLen, 3);

    // R5 type not wanted, then R4 region 1
    place(2, 3, 0); outcome(2, kept, rejLen, qCycles);
    check(kept == 0, "R5", "site2 unwanted type", kept, 0);
    place(3, 0, 0); outcome(3, kept, rejLen, qCycles);
    check(kept == 1, "R4", "site3 kept", kept, 1);
    place(7, 0, 0); outcome(7, kept, rejLen, qCycles);
    check(kept == 0, "R5", "site7 region1 full", kept, 0);

    // R5 tag outside the type range
    place(10, 6, 0); outcome(10, kept, rejLen, qCycles);
    check(kept == 0, "R5", "site10 invalid tag", kept, 0);

    // R7 silent tag
    place(15, 4, 1); outcome(15, kept, rejLen, qCycles);
    check(kept == 0, "R7", "timeout reject", kept, 0);
    check(qCycles == TIMEOUT, "R7", "query cycles", qCycles, TIMEOUT);
    place(15, 4, 0); outcome(15, kept, rejLen, qCycles);
    check(kept == 1, "R4", "site15 kept after retry", kept, 1);
    check(allDone == 1'b1, "R10", "allDone all met", int'(allDone), 1);

    // R8 departure restores the requirement
    occ[0] = 1'b0;
    @(negedge clk);
    check(siteKept[0] == 1'b0, "R8", "site0 kept cleared", int'(siteKept[0]), 0);
    check(allDone == 1'b0, "R8", "requirement restored", int'(allDone), 0);
    place(1, 2, 0); outcome(1, kept, rejLen, qCycles);
    check(kept == 1, "R8", "site1 refills region0", kept, 1);
    check(allDone == 1'b1, "R8", "allDone after refill", int'(allDone), 1);

    // R9 part leaves during its query
    place(8, 1, 1);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (qryReq && qrySite == 4'd8) break;
    end
    occ[8] = 1'b0;
    repeat (2) @(negedge clk);
    check(qryReq == 1'b0, "R9", "query dropped", int'(qryReq), 0);
    check(siteReject[8] == 1'b0, "R9", "no reject", int'(siteReject[8]), 0);
    check(siteKept[8] == 1'b0, "R9", "no keep", int'(siteKept[8]), 0);
    check(allDone == 1'b1, "R9", "counters untouched", int'(allDone), 1);
    silent[8] = 1'b0;

    // R6 hold lengths 0 (treated as 1) and 5
    rejHold = 4'd0;
    place(12, 1, 0); outcome(12, kept, rejLen, qCycles);
    check(rejLen == 1, "R6", "reject hold 0", rejLen, 1);
    rejHold = 4'd5;
    place(13, 1, 0); outcome(13, kept, rejLen, qCycles);
    check(rejLen == 5, "R6", "reject hold 5", rejLen, 5);

    // R4 R5 sweep every tag value against region 2 needing one of each type
    for (int t = 0; t < 5; t++) cfgWrite(2, t, 1);
    check(allDone == 1'b0, "R2", "region2 loaded", int'(allDone), 0);
    rejHold = 4'd2;
    for (int tag = 0; tag < 8; tag++) begin
      place(9, tag, 0); outcome(9, kept, rejLen, qCycles);
      check(kept == ((tag < 5) ? 1 : 0), "R4", $sformatf("sweep tag %0d", tag),
            kept, (tag < 5) ? 1 : 0);
      occ[9] = 1'b0;
      repeat (2) @(negedge clk);
    end
    check(allDone == 1'b0, "R8", "sweep departures restored", int'(allDone), 0);
    for (int t = 0; t < 5; t++) cfgWrite(2, t, 0);
    check(allDone == 1'b1, "R2", "load overrides to zero", int'(allDone), 1);

    // R3 simultaneous arrivals are all served
    begin
      bit seen [3];
      for (int i = 0; i < 3; i++) begin seen[i] = 1'b0; place(12 + i, 0, 0); end
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
          if (siteReject[12 + i]) begin seen[i] = 1'b1; occ[12 + i] = 1'b0; end
        end
        if (seen[0] && seen[1] && seen[2]) break;
      end
      for (int i = 0; i < 3; i++)
        check(seen[i], "R3", $sformatf("site %0d served", 12 + i), int'(seen[i]), 1);
    end

    repeat (8) @(negedge clk);
    summary();
  end
endmodule